// File: doc/BRIEF.md
# RISC Instruction Class Decoder

This block classifies a 32-bit instruction word of a fixed-width load/store RISC machine. It returns an operation code and three flags. The undefined flag marks encodings that the pipeline does not support. The load flag marks instructions that read memory, and the store flag marks instructions that write it. Condition codes are not evaluated here. Operands are not fetched and nothing is executed; a downstream issue stage consumes the code and flags.

The word is first split by its major type field in bits 27:25. Inside the register data-processing type, a fixed sequence of mask/match tests runs before the generic 16-way ALU opcode mapping. These tests find branch-exchange, multiply, long multiply, the two status-register moves and the halfword/signed-byte transfers. The decode is combinational. Its result is captured in an output register whenever the valid strobe is high. The register holds its value otherwise and returns to the no-operation code on a synchronous reset.

Top module: `insn_class_decoder`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs go to code 0 (no-operation) with `undef_o`, `load_o` and `store_o` all low, whatever `valid_i` is.
- R2: At a rising edge with `valid_i` high, the decode of `insn_i` appears on the outputs. With `valid_i` low, the outputs keep their values.
- R3: The word 0x00000000 decodes as code 0 before any other test. Any nonzero word is decoded by type.
- R4: In type 0 the tests run in a fixed order. First, (word & 0x0FFFFFF0) == 0x012FFF10 gives code 2 (branch-exchange). Next, (word & 0x0F8000F0) == 0x00000090 gives code 3 (multiply). Then the same mask with match 0x00800090 gives code 4 (long multiply). Only after these does the halfword test run.
- R5: In type 0, (word & 0x0FBF0FFF) == 0x010F0000 and (word & 0x0FBFFFF0) == 0x0129F000 both decode as code 1 (undefined).
- R6: In type 0, if (word & 0x0E000090) == 0x00000090 and no earlier test matched, the word is a halfword/signed transfer. Let L be bit 20, R be 1 when bit 22 is clear, and SH be bits 6:5. Nonzero SH gives code 56 + 8·L + 4·R + (SH − 1). SH = 0 gives code 1.
- R7: Any other type-0 word gives code 16 + bits 24:21. A type-1 word that is not a swap gives code 32 + bits 24:21.
- R8: A type-1 word with bits 24:23 = 10, bits 21:20 = 00 and bits 11:4 = 0x09 is a swap. It gives code 10, or code 11 when bit 22 is set, and raises both `load_o` and `store_o`.
- R9: Types 2 and 3 give code 48 + 4·(type is 3) + 2·(bit 20 clear) + bit 22.
- R10: Type 4 gives code 8 when bit 20 is set and code 9 when it is clear. Type 5 gives code 6 when bit 24 is set and code 5 when it is clear.
- R11: Type 7 with bit 24 set gives code 7 (software trap). Type 7 with bit 24 clear gives code 1, and so does every type-6 word.
- R12: `load_o` is high exactly for codes 8, 10 and 11, for single transfers with bit 20 set, and for defined halfword transfers with bit 20 set. `store_o` is high exactly for codes 9, 10 and 11, for single transfers with bit 20 clear, and for defined halfword transfers with bit 20 clear. `undef_o` is high exactly when the code is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Capture strobe for `insn_i` |
| insn_i | input | 32 | Instruction word |
| op_o | output | 7 | Registered operation code |
| undef_o | output | 1 | Registered unsupported-encoding flag |
| load_o | output | 1 | Registered memory-read flag |
| store_o | output | 1 | Registered memory-write flag |

## Verification
Every result is due exactly one rising edge after the edge that samples `valid_i` high. The bench drives the word and strobe on a falling edge and samples all four outputs on the next falling edge. That is one register stage later, with no extra slack. The hold case also spans one edge: the strobe is dropped, a different word is driven, and the old result must still be present at the following falling edge. A reset issued while the strobe is high must show the no-operation code at that same next falling edge.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

    localparam int INSN_W   = 32;
    localparam int OP_W     = 7;
    localparam int TYPE_HI  = 27;
    localparam int TYPE_LO  = 25;
    localparam int TYPE_W   = TYPE_HI - TYPE_LO + 1;
    localparam int ALU_HI   = 24;
    localparam int ALU_LO   = 21;
    localparam int ALU_W    = ALU_HI - ALU_LO + 1;
    localparam int LOAD_BIT = 20;
    localparam int BYTE_BIT = 22;
    localparam int LINK_BIT = 24;
    localparam int SH_HI    = 6;
    localparam int SH_LO    = 5;
    localparam int SH_W     = SH_HI - SH_LO + 1;

    typedef logic [OP_W-1:0] opcode_t;

    localparam opcode_t OP_NOP       = 7'd0;
    localparam opcode_t OP_UNDEF     = 7'd1;
    localparam opcode_t OP_BXCH      = 7'd2;
    localparam opcode_t OP_MUL       = 7'd3;
    localparam opcode_t OP_MULL      = 7'd4;
    localparam opcode_t OP_BRANCH    = 7'd5;
    localparam opcode_t OP_BR_LINK   = 7'd6;
    localparam opcode_t OP_TRAP      = 7'd7;
    localparam opcode_t OP_LD_MULTI  = 7'd8;
    localparam opcode_t OP_ST_MULTI  = 7'd9;
    localparam opcode_t OP_SWAP_W    = 7'd10;
    localparam opcode_t OP_SWAP_B    = 7'd11;
    localparam opcode_t OP_ALU_R     = 7'd16;
    localparam opcode_t OP_ALU_I     = 7'd32;
    localparam opcode_t OP_SXFER     = 7'd48;
    localparam opcode_t OP_HXFER     = 7'd56;

    typedef enum logic [TYPE_W-1:0] {
        CLS_REG_DP   = 3'd0,
        CLS_IMM_DP   = 3'd1,
        CLS_XFER_OFS = 3'd2,
        CLS_XFER_IDX = 3'd3,
        CLS_BLOCK    = 3'd4,
        CLS_BRANCH   = 3'd5,
        CLS_COPROC   = 3'd6,
        CLS_SYS      = 3'd7
    } cls_e;

    typedef struct packed {
        opcode_t op;
        logic    undef;
        logic    ld;
        logic    st;
    } dec_t;

    // Special encodings inside the register data-processing type, in test order.
    localparam int N_SPEC    = 6;
    localparam int SPEC_BX   = 0;
    localparam int SPEC_MUL  = 1;
    localparam int SPEC_MULL = 2;
    localparam int SPEC_SRRD = 3;
    localparam int SPEC_SRWR = 4;
    localparam int SPEC_HX   = 5;
    localparam int SEL_W     = $clog2(N_SPEC + 1);

    localparam logic [INSN_W-1:0] SPEC_MASK [N_SPEC] = '{
        32'h0FFF_FFF0, 32'h0F80_00F0, 32'h0F80_00F0,
        32'h0FBF_0FFF, 32'h0FBF_FFF0, 32'h0E00_0090
    };
    localparam logic [INSN_W-1:0] SPEC_MATCH [N_SPEC] = '{
        32'h012F_FF10, 32'h0000_0090, 32'h0080_0090,
        32'h010F_0000, 32'h0129_F000, 32'h0000_0090
    };

    // Swap pattern inside the immediate type (bits 24:20 and 11:4).
    localparam logic [1:0] SWAP_HI_PAT  = 2'b10;
    localparam logic [1:0] SWAP_LO_PAT  = 2'b00;
    localparam logic [7:0] SWAP_MID_PAT = 8'h09;

    function automatic dec_t mk_dec(opcode_t op, logic ld, logic st);
        dec_t d;
        d.op    = op;
        d.undef = (op == OP_UNDEF);
        d.ld    = ld;
        d.st    = st;
        return d;
    endfunction

    function automatic opcode_t alu_code(logic imm, logic [ALU_W-1:0] opc);
        opcode_t base;
        base = imm ? OP_ALU_I : OP_ALU_R;
        return opcode_t'(base + opcode_t'(opc));
    endfunction

    function automatic opcode_t sxfer_code(logic idx, logic ld, logic byt);
        return opcode_t'(OP_SXFER + opcode_t'({idx, ~ld, byt}));
    endfunction

    function automatic opcode_t hxfer_code(logic ld, logic reg_form, logic [SH_W-1:0] sh);
        logic [SH_W-1:0] variant;
        variant = sh - SH_W'(1);
        return opcode_t'(OP_HXFER + opcode_t'({ld, reg_form, variant}));
    endfunction

endpackage

// File: rtl/insn_special_dec.sv
module insn_special_dec
    import insn_dec_pkg::*;
(
    input  logic [INSN_W-1:0] word_i,
    output logic              hit_o,
    output dec_t              dec_o
);

    logic [N_SPEC-1:0] hits;
    logic [SEL_W-1:0]  sel;
    logic [SH_W-1:0]   sh;
    logic              ld_bit;
    logic              reg_form;

    genvar g;
    generate
        for (g = 0; g < N_SPEC; g++) begin : g_pattern
            assign hits[g] = ((word_i & SPEC_MASK[g]) == SPEC_MATCH[g]);
        end
    endgenerate

    // Lowest index wins: that is the fixed test order.
    always_comb begin
        sel = SEL_W'(N_SPEC);
        for (int i = N_SPEC - 1; i >= 0; i--) begin
            if (hits[i]) sel = SEL_W'(i);
        end
    end

    assign hit_o    = |hits;
    assign sh       = word_i[SH_HI:SH_LO];
    assign ld_bit   = word_i[LOAD_BIT];
    assign reg_form = ~word_i[BYTE_BIT];

    always_comb begin
        dec_o = mk_dec(OP_UNDEF, 1'b0, 1'b0);
        case (sel)
            SEL_W'(SPEC_BX):   dec_o = mk_dec(OP_BXCH, 1'b0, 1'b0);
            SEL_W'(SPEC_MUL):  dec_o = mk_dec(OP_MUL,  1'b0, 1'b0);
            SEL_W'(SPEC_MULL): dec_o = mk_dec(OP_MULL, 1'b0, 1'b0);
            SEL_W'(SPEC_SRRD),
            SEL_W'(SPEC_SRWR): dec_o = mk_dec(OP_UNDEF, 1'b0, 1'b0);
            SEL_W'(SPEC_HX): begin
                if (sh == '0)
                    dec_o = mk_dec(OP_UNDEF, 1'b0, 1'b0);
                else
                    dec_o = mk_dec(hxfer_code(ld_bit, reg_form, sh), ld_bit, ~ld_bit);
            end
            default:           dec_o = mk_dec(OP_UNDEF, 1'b0, 1'b0);
        endcase
    end

endmodule

// File: rtl/insn_imm_dec.sv
module insn_imm_dec
    import insn_dec_pkg::*;
(
    input  logic [ALU_HI:LOAD_BIT] hi_i,
    input  logic [11:4]            mid_i,
    output dec_t                   dec_o
);

    logic is_swap;

    assign is_swap = (hi_i[ALU_HI:ALU_HI-1] == SWAP_HI_PAT)
                  && (hi_i[LOAD_BIT+1:LOAD_BIT] == SWAP_LO_PAT)
                  && (mid_i == SWAP_MID_PAT);

    always_comb begin
        if (is_swap)
            dec_o = mk_dec(hi_i[BYTE_BIT] ? OP_SWAP_B : OP_SWAP_W, 1'b1, 1'b1);
        else
            dec_o = mk_dec(alu_code(1'b1, hi_i[ALU_HI:ALU_LO]), 1'b0, 1'b0);
    end

endmodule

// File: rtl/insn_xfer_dec.sv
module insn_xfer_dec
    import insn_dec_pkg::*;
(
    input  cls_e cls_i,
    input  logic ld_i,
    input  logic byte_i,
    output dec_t dec_o
);

    always_comb begin
        case (cls_i)
            CLS_XFER_OFS: dec_o = mk_dec(sxfer_code(1'b0, ld_i, byte_i), ld_i, ~ld_i);
            CLS_XFER_IDX: dec_o = mk_dec(sxfer_code(1'b1, ld_i, byte_i), ld_i, ~ld_i);
            CLS_BLOCK:    dec_o = mk_dec(ld_i ? OP_LD_MULTI : OP_ST_MULTI, ld_i, ~ld_i);
            default:      dec_o = mk_dec(OP_UNDEF, 1'b0, 1'b0);
        endcase
    end

endmodule

// File: rtl/insn_ctl_dec.sv
module insn_ctl_dec
    import insn_dec_pkg::*;
(
    input  cls_e cls_i,
    input  logic bit24_i,
    output dec_t dec_o
);

    always_comb begin
        case (cls_i)
            CLS_BRANCH: dec_o = mk_dec(bit24_i ? OP_BR_LINK : OP_BRANCH, 1'b0, 1'b0);
            CLS_SYS:    dec_o = mk_dec(bit24_i ? OP_TRAP : OP_UNDEF, 1'b0, 1'b0);
            default:    dec_o = mk_dec(OP_UNDEF, 1'b0, 1'b0);
        endcase
    end

endmodule

// File: rtl/insn_class_decoder.sv
module insn_class_decoder
    import insn_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [INSN_W-1:0] insn_i,
    output logic [OP_W-1:0]   op_o,
    output logic              undef_o,
    output logic              load_o,
    output logic              store_o
);

    cls_e cls;
    logic spec_hit;
    dec_t spec_dec;
    dec_t imm_dec;
    dec_t xfer_dec;
    dec_t ctl_dec;
    dec_t dec_nx;
    dec_t dec_q;

    assign cls = cls_e'(insn_i[TYPE_HI:TYPE_LO]);

    insn_special_dec u_special (
        .word_i (insn_i),
        .hit_o  (spec_hit),
        .dec_o  (spec_dec)
    );

    insn_imm_dec u_imm (
        .hi_i  (insn_i[ALU_HI:LOAD_BIT]),
        .mid_i (insn_i[11:4]),
        .dec_o (imm_dec)
    );

    insn_xfer_dec u_xfer (
        .cls_i  (cls),
        .ld_i   (insn_i[LOAD_BIT]),
        .byte_i (insn_i[BYTE_BIT]),
        .dec_o  (xfer_dec)
    );

    insn_ctl_dec u_ctl (
        .cls_i   (cls),
        .bit24_i (insn_i[LINK_BIT]),
        .dec_o   (ctl_dec)
    );

    always_comb begin
        if (insn_i == '0) begin
            dec_nx = mk_dec(OP_NOP, 1'b0, 1'b0);
        end else begin
            case (cls)
                CLS_REG_DP:   dec_nx = spec_hit ? spec_dec
                                     : mk_dec(alu_code(1'b0, insn_i[ALU_HI:ALU_LO]), 1'b0, 1'b0);
                CLS_IMM_DP:   dec_nx = imm_dec;
                CLS_XFER_OFS,
                CLS_XFER_IDX,
                CLS_BLOCK:    dec_nx = xfer_dec;
                default:      dec_nx = ctl_dec;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            dec_q <= mk_dec(OP_NOP, 1'b0, 1'b0);
        else if (valid_i)
            dec_q <= dec_nx;
    end

    assign op_o    = dec_q.op;
    assign undef_o = dec_q.undef;
    assign load_o  = dec_q.ld;
    assign store_o = dec_q.st;

endmodule

// File: rtl/insn_class_decoder_chk.sv
module insn_class_decoder_chk
    import insn_dec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic [INSN_W-1:0] insn_i,
    input logic [OP_W-1:0]   op_o,
    input logic              undef_o,
    input logic              load_o,
    input logic              store_o
);

    assert_reset_nop_R1: assert property (@(posedge clk)
        rst |=> (op_o == OP_NOP) && !undef_o && !load_o && !store_o);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(op_o) && $stable(undef_o) && $stable(load_o) && $stable(store_o));

    assert_zero_nop_R3: assert property (@(posedge clk) disable iff (rst)
        valid_i && (insn_i == '0) |=> (op_o == OP_NOP));

    assert_bxch_first_R4: assert property (@(posedge clk) disable iff (rst)
        valid_i && ((insn_i & 32'h0FFF_FFF0) == 32'h012F_FF10) |=> (op_o == OP_BXCH));

    assert_mul_first_R4: assert property (@(posedge clk) disable iff (rst)
        valid_i && ((insn_i & 32'h0F80_00F0) == 32'h0000_0090) |=> (op_o == OP_MUL));

    assert_swap_both_R8: assert property (@(posedge clk) disable iff (rst)
        (op_o == OP_SWAP_W || op_o == OP_SWAP_B) |-> load_o && store_o);

    assert_branch_link_R10: assert property (@(posedge clk) disable iff (rst)
        valid_i && (insn_i[TYPE_HI:TYPE_LO] == 3'd5)
        |=> (op_o == ($past(insn_i[LINK_BIT]) ? OP_BR_LINK : OP_BRANCH)));

    assert_coproc_undef_R11: assert property (@(posedge clk) disable iff (rst)
        valid_i && (insn_i[TYPE_HI:TYPE_LO] == 3'd6) |=> undef_o && !load_o && !store_o);

    assert_undef_flag_R12: assert property (@(posedge clk) disable iff (rst)
        undef_o == (op_o == OP_UNDEF));

    assert_block_flags_R12: assert property (@(posedge clk) disable iff (rst)
        (op_o == OP_LD_MULTI) |-> load_o && !store_o);

endmodule

bind insn_class_decoder insn_class_decoder_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .valid_i (valid_i),
    .insn_i  (insn_i),
    .op_o    (op_o),
    .undef_o (undef_o),
    .load_o  (load_o),
    .store_o (store_o)
);

// File: tb/insn_class_decoder_test.sv
module insn_class_decoder_test;
    import insn_dec_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 28;

    // {word, expected code, expected load, expected store}
    localparam logic [40:0] VEC [N_VEC] = '{
        {32'h0000_0000, 7'd0,  1'b0, 1'b0},   // R3 zero word
        {32'hE12F_FF1E, 7'd2,  1'b0, 1'b0},   // R4 branch-exchange
        {32'hE000_0291, 7'd3,  1'b0, 1'b0},   // R4 multiply ahead of halfword test
        {32'hE081_0392, 7'd4,  1'b0, 1'b0},   // R4 long multiply
        {32'hE10F_0000, 7'd1,  1'b0, 1'b0},   // R5 status read
        {32'hE129_F001, 7'd1,  1'b0, 1'b0},   // R5 status write
        {32'hE1D1_00B2, 7'd64, 1'b1, 1'b0},   // R6 load half, offset form
        {32'hE181_00F2, 7'd62, 1'b0, 1'b1},   // R6 store signed half, register form
        {32'hE191_00D2, 7'd69, 1'b1, 1'b0},   // R6 load signed byte, register form
        {32'hE1D1_0090, 7'd1,  1'b0, 1'b0},   // R6 SH zero
        {32'hE081_2003, 7'd20, 1'b0, 1'b0},   // R7 register ALU opcode 4
        {32'hE1E0_0001, 7'd31, 1'b0, 1'b0},   // R7 register ALU opcode 15
        {32'h0000_0001, 7'd16, 1'b0, 1'b0},   // R3 nonzero word, opcode 0
        {32'hE241_1001, 7'd34, 1'b0, 1'b0},   // R7 immediate ALU opcode 2
        {32'hE3A0_0005, 7'd45, 1'b0, 1'b0},   // R7 immediate ALU opcode 13
        {32'hE300_0090, 7'd10, 1'b1, 1'b1},   // R8 word swap
        {32'hE340_0090, 7'd11, 1'b1, 1'b1},   // R8 byte swap
        {32'hE591_2000, 7'd48, 1'b1, 1'b0},   // R9 load word, offset
        {32'hE5C1_2000, 7'd51, 1'b0, 1'b1},   // R9 store byte, offset
        {32'hE7D1_2003, 7'd53, 1'b1, 1'b0},   // R9 load byte, index
        {32'hE781_2003, 7'd54, 1'b0, 1'b1},   // R9 store word, index
        {32'hE8BD_000F, 7'd8,  1'b1, 1'b0},   // R10 load multiple
        {32'hE92D_4000, 7'd9,  1'b0, 1'b1},   // R10 store multiple
        {32'hEA00_0010, 7'd5,  1'b0, 1'b0},   // R10 branch
        {32'hEB00_0010, 7'd6,  1'b0, 1'b0},   // R10 branch with link
        {32'hEF00_0011, 7'd7,  1'b0, 1'b0},   // R11 software trap
        {32'hEE00_0010, 7'd1,  1'b0, 1'b0},   // R11 type 7 without bit 24
        {32'hED90_0000, 7'd1,  1'b0, 1'b0}    // R11 type 6
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              valid_i;
    logic [INSN_W-1:0] insn_i;
    logic [OP_W-1:0]   op_o;
    logic              undef_o;
    logic              load_o;
    logic              store_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    insn_class_decoder uut (
        .clk     (clk),
        .rst     (rst),
        .valid_i (valid_i),
        .insn_i  (insn_i),
        .op_o    (op_o),
        .undef_o (undef_o),
        .load_o  (load_o),
        .store_o (store_o)
    );

    // undef is expected exactly for code 1 (R12).
    task automatic check(input string req, input logic [OP_W-1:0] eop,
                         input logic eld, input logic est);
        logic eundef;
        eundef = (eop == 7'd1);
        checks++;
        if (op_o !== eop || undef_o !== eundef || load_o !== eld || store_o !== est) begin
            fails++;
            $display("FAIL %s: op=%0d undef=%b ld=%b st=%b expected op=%0d undef=%b ld=%b st=%b",
                     req, op_o, undef_o, load_o, store_o, eop, eundef, eld, est);
        end
    endtask

    // Drive on a falling edge; the result is due after the next rising edge.
    task automatic apply(input logic v, input logic [INSN_W-1:0] w);
        @(negedge clk);
        valid_i = v;
        insn_i  = w;
        @(negedge clk);
    endtask

    initial begin
        rst     = 1'b1;
        valid_i = 1'b1;
        insn_i  = 32'hEB00_0010;
        repeat (3) @(negedge clk);
        check("R1 reset state with valid high", 7'd0, 1'b0, 1'b0);
        rst     = 1'b0;
        valid_i = 1'b0;

        for (int i = 0; i < N_VEC; i++) begin
            apply(1'b1, VEC[i][40:9]);
            check($sformatf("table[%0d] word %08h", i, VEC[i][40:9]),
                  VEC[i][8:2], VEC[i][1], VEC[i][0]);
        end

        // R2: capture then hold with valid low
        apply(1'b1, 32'hEB00_0010);
        check("R2 capture", 7'd6, 1'b0, 1'b0);
        apply(1'b0, 32'hE8BD_000F);
        check("R2 hold while valid low", 7'd6, 1'b0, 1'b0);
        apply(1'b1, 32'hE8BD_000F);
        check("R2 update after hold", 7'd8, 1'b1, 1'b0);

        // R3: zero word after a swap clears every flag
        apply(1'b1, 32'hE300_0090);
        apply(1'b1, 32'h0000_0000);
        check("R3 zero after swap", 7'd0, 1'b0, 1'b0);

        // R1: mid-run reset overrides a valid word
        apply(1'b1, 32'hE5C1_2000);
        @(negedge clk);
        rst     = 1'b1;
        valid_i = 1'b1;
        insn_i  = 32'hE591_2000;
        @(negedge clk);
        check("R1 reset mid-run", 7'd0, 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R2 first capture after reset", 7'd48, 1'b1, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule